// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the controller side of a low-power DDR SDRAM command bus. On every rising clock edge it samples the clock enable, the chip select, the three command strobes (RAS, CAS, WE), the bank address and the address bus. From these it works out which command the memory is receiving. It keeps a record of the open row in each bank, holds copies of the main and extended mode registers, and follows the power state that the memory enters when clock enable drops.

A monitor or controller can use it to predict the memory's internal state without modelling the whole device. It reports the decoded command, the open or idle state and the row of each bank, both mode register images and the current power state. It also flags commands that are illegal for the present bank state. Data, strobe timing, refresh counting and timing-parameter checks are handled elsewhere.

All outputs are registered. A sample taken at a rising edge is visible on the outputs right after that edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When cs_n_i is sampled high with clock enable high in the run state, the sample is treated as a no-operation: cmd_o reads 0 (NOP) and no bank, row or mode register changes.
- R2: With cs_n_i low, the pins {ras_n_i,cas_n_i,we_n_i} decode as 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH, 000 MODE SET and 111 NOP. The code 110 is treated as NOP. cmd_o reports NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, REFRESH=5, MODE SET=6.
- R3: ACTIVE to an idle bank b (b = ba_i) sets bank_open_o[b] and loads open_row_o[b*ROW_W +: ROW_W] with addr_i[ROW_W-1:0]. A bank that is idle shows row 0.
- R4: A READ or WRITE to an open bank with addr_i[10] (the auto-precharge bit) high closes that bank after the access. With addr_i[10] low the bank stays open with its row unchanged.
- R5: PRECHARGE with addr_i[10] low closes only bank ba_i. With addr_i[10] high it closes every bank.
- R6: MODE SET with ba_i=0 loads addr_i into mode_reg_o. With ba_i=2 it loads addr_i into ext_mode_reg_o. With ba_i equal to 1 or 3 neither register changes.
- R7: A sample with cke_i low in the run state selects the next state on pwr_state_o, and no command is decoded (cmd_o = NOP). If any bank is open, the state is active power-down (2). If all banks are idle and REFRESH is presented with cs_n_i low, the state is self refresh (3). Otherwise it is precharge power-down (1). Run is 0.
- R8: While pwr_state_o is non-zero, every input except cke_i is ignored. This includes the sample where cke_i returns high, which moves the state back to run (0) and is itself not decoded.
- R9: Leaving active or precharge power-down keeps every bank's open state and row. Leaving self refresh leaves all banks idle.
- R10: err_o is high for one cycle after a READ or WRITE to an idle bank, or an ACTIVE to an open bank. Such a command changes no bank state.
- R11: After reset all banks are idle with row 0, both mode registers are 0, pwr_state_o is 0, cmd_o is NOP and err_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable as seen by the memory |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| ba_i | input | BA_W (2) | Bank address |
| addr_i | input | ADDR_W (13) | Row, column/auto-precharge or opcode |
| cmd_o | output | 3 | Decoded command of the last sample |
| err_o | output | 1 | Illegal command for bank state |
| bank_open_o | output | NUM_BANKS (4) | One bit per bank, set while a row is open |
| open_row_o | output | NUM_BANKS*ROW_W (52) | Open row per bank, bank b at b*ROW_W |
| mode_reg_o | output | ADDR_W (13) | Main mode register image |
| ext_mode_reg_o | output | ADDR_W (13) | Extended mode register image |
| pwr_state_o | output | 2 | 0 run, 1 precharge power-down, 2 active power-down, 3 self refresh |

## Verification
The properties assume that every input is a clean, known level at each rising edge. They also assume that the state reported on the ports reflects only what was sampled. No property depends on timing spacing between commands, because the block enforces none. The stimulus holds every pin steady from the falling edge to the next falling edge. It mixes masked samples, all eight strobe codes and clock-enable drops in both bank conditions, so illegal command orders arise freely without leaving those assumptions.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4,
      CMD_REF = 3'd5,
      CMD_MRS = 3'd6
   } cmd_e;

   typedef enum logic [1:0] {
      PW_RUN    = 2'd0,
      PW_PD_PRE = 2'd1,
      PW_PD_ACT = 2'd2,
      PW_SREF   = 2'd3
   } pwr_e;

   // Strobe code {ras_n, cas_n, we_n} to command, chip select already applied
   function automatic cmd_e strobe_to_cmd(input logic [2:0] rcw);
      cmd_e c;
      case (rcw)
         3'b011:  c = CMD_ACT;
         3'b101:  c = CMD_RD;
         3'b100:  c = CMD_WR;
         3'b010:  c = CMD_PRE;
         3'b001:  c = CMD_REF;
         3'b000:  c = CMD_MRS;
         default: c = CMD_NOP;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_trk_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e raw_cmd
);

   always_comb begin
      if (cs_n) raw_cmd = CMD_NOP;
      else      raw_cmd = strobe_to_cmd({ras_n, cas_n, we_n});
   end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
   import sdram_trk_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 13,
   parameter int ADDR_W    = 13,
   parameter int AP_BIT    = 10,
   localparam int BA_W     = $clog2(NUM_BANKS),
   localparam int ROWS_W   = NUM_BANKS * ROW_W
)
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  cmd_e                 cmd,
   input  logic [BA_W-1:0]      ba,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 clear_all,
   output logic [NUM_BANKS-1:0] open_o,
   output logic [ROWS_W-1:0]    rows_o,
   output logic                 err_o
);

   logic [NUM_BANKS-1:0] open_q;
   logic                 sel_open;
   logic                 ap_flag;
   logic                 bad_cmd;

   assign sel_open = open_q[ba];
   assign ap_flag  = addr[AP_BIT];

   always_comb begin
      bad_cmd = 1'b0;
      if (en) begin
         if ((cmd == CMD_RD || cmd == CMD_WR) && !sel_open) bad_cmd = 1'b1;
         if (cmd == CMD_ACT && sel_open)                    bad_cmd = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_o <= 1'b0;
      else        err_o <= bad_cmd;
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic             hit;
      logic             do_open;
      logic             do_close;
      logic [ROW_W-1:0] row_q;

      assign hit     = (ba == BA_W'(b));
      assign do_open = en && hit && cmd == CMD_ACT && !open_q[b];

      always_comb begin
         do_close = 1'b0;
         if (clear_all) do_close = 1'b1;
         else if (en) begin
            case (cmd)
               CMD_PRE: do_close = ap_flag || hit;
               CMD_RD,
               CMD_WR:  do_close = hit && ap_flag && open_q[b];
               default: do_close = 1'b0;
            endcase
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_q[b] <= 1'b0;
            row_q     <= '0;
         end else if (do_open) begin
            open_q[b] <= 1'b1;
            row_q     <= addr[ROW_W-1:0];
         end else if (do_close) begin
            open_q[b] <= 1'b0;
            row_q     <= '0;
         end
      end

      assign rows_o[b*ROW_W +: ROW_W] = row_q;
   end

   assign open_o = open_q;

endmodule

// File: rtl/sdram_mode_regs.sv
module sdram_mode_regs
   import sdram_trk_pkg::*;
#(
   parameter int ADDR_W  = 13,
   parameter int BA_W    = 2,
   parameter int MR_SEL  = 0,
   parameter int EMR_SEL = 2
)
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  cmd_e              cmd,
   input  logic [BA_W-1:0]   ba,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] mr_o,
   output logic [ADDR_W-1:0] emr_o
);

   logic load;
   assign load = en && cmd == CMD_MRS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mr_o  <= '0;
         emr_o <= '0;
      end else if (load) begin
         if (ba == BA_W'(MR_SEL))  mr_o  <= addr;
         if (ba == BA_W'(EMR_SEL)) emr_o <= addr;
      end
   end

endmodule

// File: rtl/sdram_power_fsm.sv
module sdram_power_fsm
   import sdram_trk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  cmd_e raw_cmd,
   input  logic any_open,
   output pwr_e state_o,
   output logic run_en,
   output logic sref_exit
);

   pwr_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         PW_RUN: begin
            if (!cke) begin
               if (any_open)                st_d = PW_PD_ACT;
               else if (raw_cmd == CMD_REF) st_d = PW_SREF;
               else                         st_d = PW_PD_PRE;
            end
         end
         default: if (cke) st_d = PW_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PW_RUN;
      else        st_q <= st_d;
   end

   assign state_o   = st_q;
   assign run_en    = (st_q == PW_RUN) && cke;
   assign sref_exit = (st_q == PW_SREF) && cke;

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
   import sdram_trk_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 13,
   parameter int ADDR_W    = 13,
   parameter int AP_BIT    = 10,
   parameter int MR_SEL    = 0,
   parameter int EMR_SEL   = 2,
   localparam int BA_W     = $clog2(NUM_BANKS),
   localparam int ROWS_W   = NUM_BANKS * ROW_W
)
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke_i,
   input  logic                 cs_n_i,
   input  logic                 ras_n_i,
   input  logic                 cas_n_i,
   input  logic                 we_n_i,
   input  logic [BA_W-1:0]      ba_i,
   input  logic [ADDR_W-1:0]    addr_i,
   output logic [2:0]           cmd_o,
   output logic                 err_o,
   output logic [NUM_BANKS-1:0] bank_open_o,
   output logic [ROWS_W-1:0]    open_row_o,
   output logic [ADDR_W-1:0]    mode_reg_o,
   output logic [ADDR_W-1:0]    ext_mode_reg_o,
   output logic [1:0]           pwr_state_o
);

   // Elaboration-time parameter checks
   if (NUM_BANKS < 2 || (1 << BA_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must index the address bus");
   end
   if (ROW_W > ADDR_W || ROW_W < 1) begin : g_bad_row
      $error("ROW_W must fit in the address bus");
   end
   if (MR_SEL == EMR_SEL || MR_SEL >= NUM_BANKS || EMR_SEL >= NUM_BANKS) begin : g_bad_sel
      $error("mode register selects must differ and fit the bank address");
   end

   cmd_e raw_cmd;
   pwr_e pwr;
   logic run_en;
   logic sref_exit;
   cmd_e cmd_q;

   sdram_cmd_decode u_dec (
      .cs_n    (cs_n_i),
      .ras_n   (ras_n_i),
      .cas_n   (cas_n_i),
      .we_n    (we_n_i),
      .raw_cmd (raw_cmd)
   );

   sdram_power_fsm u_pwr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cke       (cke_i),
      .raw_cmd   (raw_cmd),
      .any_open  (|bank_open_o),
      .state_o   (pwr),
      .run_en    (run_en),
      .sref_exit (sref_exit)
   );

   sdram_bank_tracker #(
      .NUM_BANKS (NUM_BANKS),
      .ROW_W     (ROW_W),
      .ADDR_W    (ADDR_W),
      .AP_BIT    (AP_BIT)
   ) u_banks (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (run_en),
      .cmd       (raw_cmd),
      .ba        (ba_i),
      .addr      (addr_i),
      .clear_all (sref_exit),
      .open_o    (bank_open_o),
      .rows_o    (open_row_o),
      .err_o     (err_o)
   );

   sdram_mode_regs #(
      .ADDR_W  (ADDR_W),
      .BA_W    (BA_W),
      .MR_SEL  (MR_SEL),
      .EMR_SEL (EMR_SEL)
   ) u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (run_en),
      .cmd   (raw_cmd),
      .ba    (ba_i),
      .addr  (addr_i),
      .mr_o  (mode_reg_o),
      .emr_o (ext_mode_reg_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_q <= CMD_NOP;
      else        cmd_q <= run_en ? raw_cmd : CMD_NOP;
   end

   assign cmd_o       = cmd_q;
   assign pwr_state_o = pwr;

endmodule

// File: rtl/sdram_trk_checker.sv
module sdram_trk_checker #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 13,
   parameter int ADDR_W    = 13,
   parameter int AP_BIT    = 10,
   parameter int MR_SEL    = 0,
   parameter int EMR_SEL   = 2,
   localparam int BA_W     = $clog2(NUM_BANKS),
   localparam int ROWS_W   = NUM_BANKS * ROW_W
)
(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cke_i,
   input logic                 cs_n_i,
   input logic                 ras_n_i,
   input logic                 cas_n_i,
   input logic                 we_n_i,
   input logic [BA_W-1:0]      ba_i,
   input logic [ADDR_W-1:0]    addr_i,
   input logic [2:0]           cmd_o,
   input logic                 err_o,
   input logic [NUM_BANKS-1:0] bank_open_o,
   input logic [ROWS_W-1:0]    open_row_o,
   input logic [ADDR_W-1:0]    mode_reg_o,
   input logic [ADDR_W-1:0]    ext_mode_reg_o,
   input logic [1:0]           pwr_state_o
);

   logic live;
   logic [2:0] rcw;
   assign live = (pwr_state_o == 2'd0) && cke_i;
   assign rcw  = {ras_n_i, cas_n_i, we_n_i};

   a_r1_masked_nop: assert property (@(posedge clk) disable iff (!rst_n)
      (live && cs_n_i) |=> (cmd_o == 3'd0 && $stable(bank_open_o) && $stable(mode_reg_o)));

   a_r5_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !cs_n_i && rcw == 3'b010 && addr_i[AP_BIT]) |=> (bank_open_o == '0));

   a_r6_mrs_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !cs_n_i && rcw == 3'b000 && ba_i != BA_W'(MR_SEL) && ba_i != BA_W'(EMR_SEL))
      |=> ($stable(mode_reg_o) && $stable(ext_mode_reg_o)));

   a_r7_active_pd: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state_o == 2'd0 && !cke_i && |bank_open_o) |=> (pwr_state_o == 2'd2 && cmd_o == 3'd0));

   a_r8_inputs_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state_o != 2'd0) |=> ($stable(bank_open_o) && $stable(open_row_o) &&
                                 $stable(mode_reg_o) && $stable(ext_mode_reg_o) && cmd_o == 3'd0));

   a_r9_pd_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state_o == 2'd2 && cke_i) |=> (pwr_state_o == 2'd0 && $stable(bank_open_o)));

   a_r10_read_idle_err: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !cs_n_i && rcw == 3'b101 && !bank_open_o[ba_i]) |=> (err_o && $stable(bank_open_o)));

endmodule

bind sdram_cmd_tracker sdram_trk_checker #(
   .NUM_BANKS (NUM_BANKS),
   .ROW_W     (ROW_W),
   .ADDR_W    (ADDR_W),
   .AP_BIT    (AP_BIT),
   .MR_SEL    (MR_SEL),
   .EMR_SEL   (EMR_SEL)
) u_chk (.*);

// File: tb/tb_sdram_cmd_tracker.sv
module tb_sdram_cmd_tracker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke_i = 1'b1;
   logic        cs_n_i = 1'b1;
   logic        ras_n_i = 1'b1;
   logic        cas_n_i = 1'b1;
   logic        we_n_i = 1'b1;
   logic [1:0]  ba_i = '0;
   logic [12:0] addr_i = '0;
   logic [2:0]  cmd_o;
   logic        err_o;
   logic [3:0]  bank_open_o;
   logic [51:0] open_row_o;
   logic [12:0] mode_reg_o;
   logic [12:0] ext_mode_reg_o;
   logic [1:0]  pwr_state_o;

   int n_chk = 0;
   int n_bad = 0;

   // reference state
   logic [3:0]  m_open;
   logic [12:0] m_row [4];
   logic [12:0] m_mr, m_emr;
   int          m_pwr, m_cmd;
   logic        m_err;

   always #10 clk = ~clk;

   sdram_cmd_tracker dut (.*);

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int code_of(input logic [2:0] rcw);
      case (rcw)
         3'b011: return 1;
         3'b101: return 2;
         3'b100: return 3;
         3'b010: return 4;
         3'b001: return 5;
         3'b000: return 6;
         default: return 0;
      endcase
   endfunction

   task automatic model_reset();
      m_open = '0; m_mr = '0; m_emr = '0; m_pwr = 0; m_cmd = 0; m_err = 1'b0;
      for (int b = 0; b < 4; b++) m_row[b] = '0;
   endtask

   task automatic model_step(input logic cke, input logic cs, input logic [2:0] rcw,
                             input logic [1:0] ba, input logic [12:0] a);
      int c;
      m_err = 1'b0;
      m_cmd = 0;
      c = cs ? 0 : code_of(rcw);
      if (m_pwr == 0) begin
         if (!cke) begin
            if (m_open != 0)  m_pwr = 2;
            else if (c == 5)  m_pwr = 3;
            else              m_pwr = 1;
         end else begin
            m_cmd = c;
            case (c)
               1: if (m_open[ba]) m_err = 1'b1;
                  else begin m_open[ba] = 1'b1; m_row[ba] = a; end
               2, 3: if (!m_open[ba]) m_err = 1'b1;
                     else if (a[10]) begin m_open[ba] = 1'b0; m_row[ba] = '0; end
               4: for (int b = 0; b < 4; b++)
                     if (a[10] || ba == b[1:0]) begin m_open[b] = 1'b0; m_row[b] = '0; end
               6: begin
                     if (ba == 2'd0) m_mr = a;
                     if (ba == 2'd2) m_emr = a;
                  end
               default: ;
            endcase
         end
      end else if (cke) begin
         if (m_pwr == 3) begin
            m_open = '0;
            for (int b = 0; b < 4; b++) m_row[b] = '0;
         end
         m_pwr = 0;
      end
   endtask

   task automatic compare(input string tag);
      logic [51:0] rows;
      for (int b = 0; b < 4; b++) rows[b*13 +: 13] = m_row[b];
      chk(tag, "cmd_o", 64'(cmd_o), 64'(m_cmd));
      chk(tag, "err_o", 64'(err_o), 64'(m_err));
      chk(tag, "bank_open_o", 64'(bank_open_o), 64'(m_open));
      chk(tag, "open_row_o", 64'(open_row_o), 64'(rows));
      chk(tag, "mode_reg_o", 64'(mode_reg_o), 64'(m_mr));
      chk(tag, "ext_mode_reg_o", 64'(ext_mode_reg_o), 64'(m_emr));
      chk(tag, "pwr_state_o", 64'(pwr_state_o), 64'(m_pwr));
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(input string tag, input logic cke, input logic cs, input logic [2:0] rcw,
                       input logic [1:0] ba, input logic [12:0] a);
      cke_i = cke; cs_n_i = cs; {ras_n_i, cas_n_i, we_n_i} = rcw; ba_i = ba; addr_i = a;
      @(posedge clk);
      model_step(cke, cs, rcw, ba, a);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5D2A_11C3));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R11");
      chk("R11", "reset pwr", 64'(pwr_state_o), 64'd0);

      // R3 open a row
      step("R3", 1, 0, 3'b011, 2'd1, 13'h0123);
      chk("R3", "row bank1", 64'(open_row_o[13 +: 13]), 64'h123);
      // R2 plain read keeps it open, R4 write with auto-precharge closes
      step("R4", 1, 0, 3'b101, 2'd1, 13'h0010);
      chk("R4", "bank1 after read", 64'(bank_open_o[1]), 64'd1);
      step("R4", 1, 0, 3'b100, 2'd1, 13'h0410);
      chk("R4", "bank1 after ap write", 64'(bank_open_o[1]), 64'd0);
      // R5 single then all
      step("R5", 1, 0, 3'b011, 2'd0, 13'h0AAA);
      step("R5", 1, 0, 3'b011, 2'd2, 13'h1555);
      step("R5", 1, 0, 3'b010, 2'd0, 13'h0000);
      chk("R5", "only bank2 open", 64'(bank_open_o), 64'h4);
      step("R1", 1, 1, 3'b011, 2'd3, 13'h0777);
      chk("R1", "masked active", 64'(bank_open_o), 64'h4);
      step("R5", 1, 0, 3'b010, 2'd3, 13'h0400);
      chk("R5", "all closed", 64'(bank_open_o), 64'h0);
      // R6 mode registers
      step("R6", 1, 0, 3'b000, 2'd0, 13'h0033);
      step("R6", 1, 0, 3'b000, 2'd2, 13'h0021);
      step("R6", 1, 0, 3'b000, 2'd1, 13'h1FFF);
      chk("R6", "mode reg", 64'(mode_reg_o), 64'h33);
      chk("R6", "ext mode reg", 64'(ext_mode_reg_o), 64'h21);
      // R10 error cases
      step("R10", 1, 0, 3'b101, 2'd3, 13'h0000);
      chk("R10", "read idle err", 64'(err_o), 64'd1);
      step("R10", 1, 0, 3'b011, 2'd3, 13'h0042);
      step("R10", 1, 0, 3'b011, 2'd3, 13'h0099);
      chk("R10", "active open err", 64'(err_o), 64'd1);
      chk("R10", "row kept", 64'(open_row_o[39 +: 13]), 64'h42);
      // R7 active power-down, R8 ignore, R9 exit keeps row
      step("R7", 0, 0, 3'b001, 2'd0, 13'h0000);
      chk("R7", "active pd", 64'(pwr_state_o), 64'd2);
      step("R8", 0, 0, 3'b010, 2'd3, 13'h0400);
      step("R8", 1, 0, 3'b010, 2'd3, 13'h0400);
      chk("R9", "bank3 kept", 64'(bank_open_o), 64'h8);
      // precharge power-down
      step("R7", 1, 0, 3'b010, 2'd3, 13'h0400);
      step("R7", 0, 0, 3'b111, 2'd0, 13'h0000);
      chk("R7", "precharge pd", 64'(pwr_state_o), 64'd1);
      step("R8", 1, 0, 3'b011, 2'd0, 13'h0001);
      chk("R8", "exit sample ignored", 64'(bank_open_o), 64'h0);
      // self refresh
      step("R7", 0, 0, 3'b001, 2'd0, 13'h0000);
      chk("R7", "self refresh", 64'(pwr_state_o), 64'd3);
      step("R8", 0, 0, 3'b000, 2'd0, 13'h1234);
      step("R9", 1, 0, 3'b111, 2'd0, 13'h0000);
      chk("R9", "sr exit idle", 64'(bank_open_o), 64'h0);

      // R2 random mix
      for (int i = 0; i < 3000; i++) begin
         logic        k, s;
         logic [2:0]  r;
         logic [1:0]  b;
         logic [12:0] a;
         if (m_pwr == 0) k = ($urandom % 8) != 0;
         else            k = ($urandom % 3) == 0;
         s = ($urandom % 8) == 0;
         r = 3'($urandom);
         b = 2'($urandom);
         a = 13'($urandom);
         step("R2", k, s, r, b, a);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule